// File: doc/BRIEF.md
# Three-Channel Shared RAM Arbiter

This block holds a byte-wide single-port RAM that three masters share: a CPU and two peripheral transfer channels. One channel has high priority and one has low priority. Every clock is one RAM cycle, and each cycle has one owner.

A peripheral raises a request level and holds its address, write data and write flag steady until it sees a one-cycle grant pulse. The RAM cycle in which the grant is high belongs to that peripheral. In that same cycle the block raises a one-wait line. If the CPU is reading or writing the RAM window during that cycle, the block also raises a hold line. The CPU then keeps its access steady for one more clock, and the block carries out the access in the next cycle.

A peripheral grant is never followed directly by another peripheral grant. The slot after a peripheral access always goes to the CPU. A low-priority request that has already been turned away once wins over the high-priority channel. This bounds its waiting time.

Top module: `shared_ram_arbiter`

## Requirements
- R1: While reset is held and with no requests, hi_gnt, lo_gnt, one_wait and cpu_hold are low and rdata reads 0.
- R2: At most one grant is high per cycle, and a grant goes only to a channel whose request is high. In a cycle that follows no peripheral grant, one channel is granted if any peripheral request is high.
- R3: If both peripheral requests are high, the low channel was not refused in the previous cycle, and the slot is free, then the high channel is granted.
- R4: If the low request was high and not granted in the previous cycle, then a free slot goes to the low channel, even when the high channel also requests.
- R5: No two consecutive cycles both carry a peripheral grant.
- R6: A low-priority request is refused in at most two consecutive cycles.
- R7: one_wait is high in exactly the cycles in which hi_gnt or lo_gnt is high.
- R8: cpu_hold is high exactly when one_wait is high and the CPU performs a read or write to the RAM window, which is cpu_addr[15:11] equal to RAM_PAGE (default 0). A held CPU access does not take place in that cycle. A CPU access outside the window never reaches the RAM.
- R9: An access is performed in its grant cycle, or for the CPU in a cycle with cpu_hold low. A write stores wdata at addr[10:0]. A read places the stored byte on rdata after the next clock edge, and rdata keeps its value until the next read.
- R10: Every channel sees the same storage: a byte written through any channel reads back unchanged through any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one RAM cycle per clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address; the upper 5 bits select the RAM window |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_hold | output | 1 | CPU must keep its RAM access for one more clock |
| one_wait | output | 1 | A peripheral owns this RAM cycle |
| hi_req | input | 1 | High-priority channel request level |
| hi_we | input | 1 | High-priority channel write flag |
| hi_addr | input | 11 | High-priority channel address |
| hi_wdata | input | 8 | High-priority channel write data |
| hi_gnt | output | 1 | High-priority channel grant pulse |
| lo_req | input | 1 | Low-priority channel request level |
| lo_we | input | 1 | Low-priority channel write flag |
| lo_addr | input | 11 | Low-priority channel address |
| lo_wdata | input | 8 | Low-priority channel write data |
| lo_gnt | output | 1 | Low-priority channel grant pulse |
| rdata | output | 8 | Read data shared by all channels |

## Verification
The bench first forces simultaneous fresh requests and checks that the high channel wins. A design with inverted priority would grant the low channel there. It then holds both requests for many cycles. This catches a design that lets the high channel win every free slot, because that design starves the low channel past two refusals. It also catches a design that grants peripherals back to back. A CPU write issued during a peripheral grant is checked to land one clock later and not in the held cycle. A CPU write outside the window is checked to leave the RAM untouched. Cross-channel readbacks expose a data path that selects the wrong owner's address or data.

// File: rtl/sra_pkg.sv
package sra_pkg;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_CPU  = 2'd1,
        OWN_HI   = 2'd2,
        OWN_LO   = 2'd3
    } owner_e;

    typedef struct packed {
        logic last_periph;
        logic lo_aged;
    } arb_state_t;

endpackage

// File: rtl/sra_arbiter.sv
module sra_arbiter
    import sra_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   hi_req,
    input  logic   lo_req,
    input  logic   cpu_access,
    output logic   hi_gnt,
    output logic   lo_gnt,
    output owner_e owner
);

    arb_state_t st_q, st_d;
    logic       slot_free;
    logic       pick_lo;

    always_comb begin
        slot_free = !st_q.last_periph;
        pick_lo   = lo_req && (st_q.lo_aged || !hi_req);
        hi_gnt    = slot_free && hi_req && !pick_lo;
        lo_gnt    = slot_free && pick_lo;
        if (hi_gnt)          owner = OWN_HI;
        else if (lo_gnt)     owner = OWN_LO;
        else if (cpu_access) owner = OWN_CPU;
        else                 owner = OWN_NONE;
        st_d.last_periph = hi_gnt || lo_gnt;
        st_d.lo_aged     = lo_req && !lo_gnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic [2:0] lo_wait_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                           lo_wait_q <= '0;
        else if (lo_req && !lo_gnt)           lo_wait_q <= (lo_wait_q == 3'd7) ? lo_wait_q : lo_wait_q + 3'd1;
        else                                  lo_wait_q <= '0;
    end

    a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hi_gnt, lo_gnt}));
    a_r2_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_gnt |-> hi_req) and (lo_gnt |-> lo_req));
    a_r5_no_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_gnt || lo_gnt) |=> !(hi_gnt || lo_gnt));
    a_r6_lo_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_req && !lo_gnt) |-> (lo_wait_q < 3'd2));
    a_r4_aged_low_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_req && !lo_gnt) ##1 (lo_req && !hi_gnt && !lo_gnt) |-> ##1 (lo_gnt || !lo_req));

endmodule

// File: rtl/sra_path_mux.sv
module sra_path_mux
    import sra_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  owner_e              owner,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                cpu_wr,
    input  logic [DATA_W-1:0]   cpu_wdata,
    input  logic [ADDR_W-1:0]   hi_addr,
    input  logic                hi_we,
    input  logic [DATA_W-1:0]   hi_wdata,
    input  logic [ADDR_W-1:0]   lo_addr,
    input  logic                lo_we,
    input  logic [DATA_W-1:0]   lo_wdata,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                mem_we,
    output logic                mem_re
);

    always_comb begin
        mem_addr  = cpu_addr;
        mem_wdata = cpu_wdata;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        unique case (owner)
            OWN_CPU: begin
                mem_we = cpu_wr;
                mem_re = !cpu_wr;
            end
            OWN_HI: begin
                mem_addr  = hi_addr;
                mem_wdata = hi_wdata;
                mem_we    = hi_we;
                mem_re    = !hi_we;
            end
            OWN_LO: begin
                mem_addr  = lo_addr;
                mem_wdata = lo_wdata;
                mem_we    = lo_we;
                mem_re    = !lo_we;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sra_mem.sv
module sra_mem #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] rdata_q, rdata_d;

    always_ff @(posedge clk) begin
        if (we) store[addr] <= wdata;
    end

    always_comb begin
        rdata_d = rdata_q;
        if (re) rdata_d = store[addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(re) |-> $stable(rdata_q));
    a_r9_one_op: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && re));

endmodule

// File: rtl/shared_ram_arbiter.sv
module shared_ram_arbiter
    import sra_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int DATA_W   = 8,
    parameter int CPU_AW   = 16,
    parameter int RAM_PAGE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_hold,
    output logic              one_wait,
    input  logic              hi_req,
    input  logic              hi_we,
    input  logic [ADDR_W-1:0] hi_addr,
    input  logic [DATA_W-1:0] hi_wdata,
    output logic              hi_gnt,
    input  logic              lo_req,
    input  logic              lo_we,
    input  logic [ADDR_W-1:0] lo_addr,
    input  logic [DATA_W-1:0] lo_wdata,
    output logic              lo_gnt,
    output logic [DATA_W-1:0] rdata
);

    localparam int PAGE_W = CPU_AW - ADDR_W;

    logic              in_page;
    logic              cpu_access;
    owner_e            owner;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_we;
    logic              mem_re;

    assign in_page    = (cpu_addr[CPU_AW-1:ADDR_W] == PAGE_W'(RAM_PAGE));
    assign cpu_access = (cpu_rd || cpu_wr) && in_page;

    sra_arbiter u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .hi_req     (hi_req),
        .lo_req     (lo_req),
        .cpu_access (cpu_access),
        .hi_gnt     (hi_gnt),
        .lo_gnt     (lo_gnt),
        .owner      (owner)
    );

    sra_path_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .owner     (owner),
        .cpu_addr  (cpu_addr[ADDR_W-1:0]),
        .cpu_wr    (cpu_wr),
        .cpu_wdata (cpu_wdata),
        .hi_addr   (hi_addr),
        .hi_we     (hi_we),
        .hi_wdata  (hi_wdata),
        .lo_addr   (lo_addr),
        .lo_we     (lo_we),
        .lo_wdata  (lo_wdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re)
    );

    sra_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .re    (mem_re),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (rdata)
    );

    assign one_wait = hi_gnt || lo_gnt;
    assign cpu_hold = one_wait && cpu_access;

    a_r8_hold_needs_wait: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hold |-> one_wait);
    a_r8_hold_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hold |=> !cpu_hold);
    a_r7_wait_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        one_wait |=> !one_wait);
    a_r8_idle_cpu_free: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rd || cpu_wr) |-> !cpu_hold);

endmodule

// File: tb/tb_shared_ram_arbiter.sv
module tb_shared_ram_arbiter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_hold, one_wait;
    logic        hi_req = 1'b0, hi_we = 1'b0;
    logic [10:0] hi_addr = '0;
    logic [7:0]  hi_wdata = '0;
    logic        hi_gnt;
    logic        lo_req = 1'b0, lo_we = 1'b0;
    logic [10:0] lo_addr = '0;
    logic [7:0]  lo_wdata = '0;
    logic        lo_gnt;
    logic [7:0]  rdata;

    always #5 clk = ~clk;

    shared_ram_arbiter dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_hold(cpu_hold), .one_wait(one_wait),
        .hi_req(hi_req), .hi_we(hi_we), .hi_addr(hi_addr), .hi_wdata(hi_wdata), .hi_gnt(hi_gnt),
        .lo_req(lo_req), .lo_we(lo_we), .lo_addr(lo_addr), .lo_wdata(lo_wdata), .lo_gnt(lo_gnt),
        .rdata(rdata)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0] m_mem [2048];
    logic [7:0] m_rdata;
    logic [7:0] m_valid [2048];
    bit  m_last, m_aged;
    int  m_lo_wait;
    bit  e_hi, e_lo, e_hold;

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit in_page(logic [15:0] a);
        return a[15:11] == 5'd0;
    endfunction

    // one RAM cycle: called just after a negedge with inputs already set
    task automatic step();
        bit acc, cpu_go;
        #1;
        e_hi = 1'b0; e_lo = 1'b0;
        if (!m_last) begin
            if (lo_req && (m_aged || !hi_req)) e_lo = 1'b1;
            else if (hi_req)                   e_hi = 1'b1;
        end
        acc    = (cpu_rd || cpu_wr) && in_page(cpu_addr);
        e_hold = (e_hi || e_lo) && acc;
        cpu_go = acc && !(e_hi || e_lo);
        chk("R2/R3/R4 hi_gnt", hi_gnt, e_hi);
        chk("R2/R3/R4 lo_gnt", lo_gnt, e_lo);
        chk("R7 one_wait", one_wait, e_hi || e_lo);
        chk("R8 cpu_hold", cpu_hold, e_hold);
        if (m_last) chk("R5 adjacent grant", hi_gnt || lo_gnt, 0);
        if (lo_req && !e_lo) m_lo_wait++; else m_lo_wait = 0;
        chk("R6 low wait bound", m_lo_wait > 2, 0);
        if (e_hi) begin
            if (hi_we) begin m_mem[hi_addr] = hi_wdata; m_valid[hi_addr] = 8'd1; end
            else m_rdata = m_mem[hi_addr];
        end else if (e_lo) begin
            if (lo_we) begin m_mem[lo_addr] = lo_wdata; m_valid[lo_addr] = 8'd1; end
            else m_rdata = m_mem[lo_addr];
        end else if (cpu_go) begin
            if (cpu_wr) begin m_mem[cpu_addr[10:0]] = cpu_wdata; m_valid[cpu_addr[10:0]] = 8'd1; end
            else m_rdata = m_mem[cpu_addr[10:0]];
        end
        m_aged = lo_req && !e_lo;
        m_last = e_hi || e_lo;
        @(posedge clk);
        #1;
        chk("R9 rdata", rdata, m_rdata);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        hi_req = 0; lo_req = 0; cpu_rd = 0; cpu_wr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 2048; i++) begin m_mem[i] = 8'h00; m_valid[i] = 8'd0; end
        m_rdata = 8'h00; m_last = 0; m_aged = 0; m_lo_wait = 0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 hi_gnt", hi_gnt, 0);
        chk("R1 lo_gnt", lo_gnt, 0);
        chk("R1 one_wait", one_wait, 0);
        chk("R1 cpu_hold", cpu_hold, 0);
        chk("R1 rdata", rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // initialise the region used by the test through the CPU
        for (int a = 0; a < 64; a++) begin
            idle_inputs(); cpu_wr = 1; cpu_addr = 16'(a); cpu_wdata = 8'(a * 3 + 1);
            step();
        end
        idle_inputs(); step();

        // R3: fresh simultaneous requests, high wins
        hi_req = 1; hi_we = 1; hi_addr = 11'd7; hi_wdata = 8'hA5;
        lo_req = 1; lo_we = 1; lo_addr = 11'd9; lo_wdata = 8'h3C;
        cpu_wr = 1; cpu_addr = 16'd20; cpu_wdata = 8'h11;
        step();
        chk("R3 hi first", e_hi, 1);
        // R8: CPU write held, performed next cycle; R4 low blocked then aged
        hi_req = 0;
        step();
        chk("R5 slot to CPU", e_lo, 0);
        cpu_wr = 0;
        hi_req = 1; hi_we = 0; hi_addr = 11'd9;
        step();
        chk("R4 aged low wins", e_lo, 1);
        lo_req = 0;
        step(); // blocked
        step(); // high read of 9
        chk("R10 low write read by high", m_rdata, 8'h3C);
        hi_req = 0;
        cpu_rd = 1; cpu_addr = 16'd20; step();
        chk("R8 held cpu write landed", rdata, 8'h11);
        cpu_addr = 16'd7; step();
        chk("R10 high write read by cpu", rdata, 8'hA5);
        // R8: out-of-window CPU write does not reach RAM
        cpu_rd = 0; cpu_wr = 1; cpu_addr = 16'h1807; cpu_wdata = 8'hFF; step();
        cpu_wr = 0; lo_req = 1; lo_we = 0; lo_addr = 11'd7; step();
        lo_req = 0; step();
        chk("R8 out-of-window write ignored", rdata, 8'hA5);
        // R6: both held continuously
        for (int k = 0; k < 12; k++) begin
            hi_req = 1; hi_we = 0; hi_addr = 11'(k);
            lo_req = 1; lo_we = 0; lo_addr = 11'(k + 1);
            step();
        end
        idle_inputs(); step(); step();

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            if (e_hi || !hi_req) begin
                hi_req = ($urandom % 3) == 0;
                hi_we = $urandom % 2; hi_addr = 11'($urandom % 64); hi_wdata = 8'($urandom);
            end
            if (e_lo || !lo_req) begin
                lo_req = ($urandom % 3) == 0;
                lo_we = $urandom % 2; lo_addr = 11'($urandom % 64); lo_wdata = 8'($urandom);
            end
            if (!e_hold) begin
                int op;
                op = $urandom % 4;
                cpu_rd = (op == 1); cpu_wr = (op == 2);
                cpu_addr = 16'($urandom % 64);
                if (($urandom % 6) == 0) cpu_addr[15:11] = 5'(1 + $urandom % 31);
                cpu_wdata = 8'($urandom);
            end
            step();
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule